// File: doc/BRIEF.md
# Packet-to-Thread Dispatcher

This block sits between an arriving stream of packet descriptors and an array of processing engines, each engine holding four thread contexts. Every accepted descriptor is handed to one free context, and that context owns the packet until it is released on the output side. A context is modelled as a countdown: it is loaded with a per-packet latency carried on the descriptor, it counts on its own whatever the other contexts are doing, and then it reports completion.

Each descriptor carries a flow identifier. On acceptance the dispatcher stamps it with a per-flow sequence number. A finished packet is only offered downstream once every older packet of its flow has left. Until then it stays parked in its context and keeps that context busy. The output is a valid/ready port. When no context is free, the input ready drops, so nothing is ever discarded.

Top module: `pkt_thread_dispatch`

## Requirements
- R1: After reset every context is free: in_ready is 1 and out_valid is 0.
- R2: A descriptor is taken only into a free context. in_ready is 0 exactly when all NUM_ENG*4 contexts are occupied. Every accepted descriptor is eventually released, with none lost.
- R3: Contexts are numbered slot = ctx*NUM_ENG + eng, so engines rotate fastest. Allocation searches round-robin, starting one past the last slot granted. After reset the grants are eng 0/ctx 0, then eng 1/ctx 0, then eng 0/ctx 1. out_eng and out_ctx name the context being released.
- R4: A descriptor accepted at clock edge k with latency L completes at edge k+L+1. Its out_valid can rise no earlier than just after that edge.
- R5: Contexts count independently. A long-latency packet does not delay the release of a packet of another flow.
- R6: Packets of one flow are released in the order they were accepted, even when a later one finishes first.
- R7: A finished packet waiting for an older packet of its flow keeps its context occupied, and that context counts toward the in_ready condition of R2.
- R8: out_seq is the per-flow sequence number. It is 0 for the first packet of a flow after reset and rises by 1, modulo 2^SEQ_W, for each later packet of that flow.
- R9: While out_valid is 1 and out_ready is 0, out_flow, out_seq and out_data hold steady. A context whose packet is accepted is free in the very next cycle.
- R10: When several finished packets are eligible together, the one in the lowest slot is offered first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Descriptor offered |
| in_ready | output | 1 | A free context exists |
| in_flow | input | FLOW_W | Flow identifier of the descriptor |
| in_data | input | DATA_W | Descriptor payload |
| in_lat | input | LAT_W | Processing latency in cycles |
| out_valid | output | 1 | Finished, in-order packet offered |
| out_ready | input | 1 | Downstream scheduler accepts |
| out_flow | output | FLOW_W | Flow of the offered packet |
| out_seq | output | SEQ_W | Per-flow sequence stamp |
| out_data | output | DATA_W | Payload of the offered packet |
| out_eng | output | log2(NUM_ENG) | Engine holding the packet |
| out_ctx | output | 2 | Context within that engine |

## Verification
A corrupted sequence counter for a flow appears at the ports as a deadlock. out_valid stays low for that flow while its contexts fill up, and in_ready falls within at most eight further packets. A context that is never returned to the free pool shows up as in_ready dropping one packet earlier than the count of outstanding packets allows. An error in the countdown shifts the rise of out_valid by a cycle relative to edge k+L+1, and the single-packet latency probe catches that on the first packet. An error in the ordering or the stamping shows on the first release through a wrong payload or a wrong out_seq, and the per-flow reference queues in the bench detect it at that release.

// File: rtl/pd_pkg.sv
package pd_pkg;

    // Life cycle of one thread context
    typedef enum logic [1:0] {
        TS_FREE = 2'd0,
        TS_BUSY = 2'd1,
        TS_DONE = 2'd2
    } thr_state_e;

endpackage

// File: rtl/pd_slot_alloc.sv
// Round-robin search for a free context, starting at a rotating pointer.
module pd_slot_alloc #(
    parameter int NT = 8,
    localparam int SLOT_W = $clog2(NT)
) (
    input  logic [NT-1:0]     free_vec,
    input  logic [SLOT_W-1:0] start,
    output logic              found,
    output logic [SLOT_W-1:0] slot
);

    logic [SLOT_W-1:0] idx;

    always_comb begin
        found = 1'b0;
        slot  = '0;
        idx   = '0;
        for (int k = 0; k < NT; k++) begin
            idx = SLOT_W'(start + SLOT_W'(k));
            if (!found && free_vec[idx]) begin
                found = 1'b1;
                slot  = idx;
            end
        end
    end

    // R2: a grant never points at an occupied context
    always_comb begin
        if (found) begin
            p_grant_free_r2: assert (free_vec[slot]);
        end
    end

endmodule

// File: rtl/pd_rel_pick.sv
// Chooses the lowest finished context whose sequence stamp is the head of its flow.
module pd_rel_pick #(
    parameter int NT     = 8,
    parameter int FLOW_W = 2,
    parameter int SEQ_W  = 4,
    localparam int SLOT_W = $clog2(NT),
    localparam int NFLOW  = 1 << FLOW_W
) (
    input  logic [NT-1:0]                done_vec,
    input  logic [NT-1:0][FLOW_W-1:0]    flow_vec,
    input  logic [NT-1:0][SEQ_W-1:0]     seq_vec,
    input  logic [NFLOW-1:0][SEQ_W-1:0]  head_seq,
    output logic                         found,
    output logic [SLOT_W-1:0]            slot
);

    logic [NT-1:0] elig;

    always_comb begin
        for (int i = 0; i < NT; i++) begin
            elig[i] = done_vec[i] && (seq_vec[i] == head_seq[flow_vec[i]]);
        end
    end

    always_comb begin
        found = 1'b0;
        slot  = '0;
        for (int i = NT - 1; i >= 0; i--) begin
            if (elig[i]) begin
                found = 1'b1;
                slot  = SLOT_W'(i);
            end
        end
    end

    // R6: only a finished context can be chosen
    always_comb begin
        if (found) begin
            p_pick_done_r6: assert (done_vec[slot]);
        end
    end

endmodule

// File: rtl/pd_flow_seq.sv
// Per-flow stamp counters: next stamp to hand out and next stamp allowed to leave.
module pd_flow_seq #(
    parameter int FLOW_W = 2,
    parameter int SEQ_W  = 4,
    parameter int NT     = 8,
    localparam int NFLOW = 1 << FLOW_W
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         asg_en,
    input  logic [FLOW_W-1:0]            asg_flow,
    output logic [SEQ_W-1:0]             asg_seq,
    input  logic                         rel_en,
    input  logic [FLOW_W-1:0]            rel_flow,
    output logic [NFLOW-1:0][SEQ_W-1:0]  head_seq
);

    typedef struct packed {
        logic [NFLOW-1:0][SEQ_W-1:0] asg;
        logic [NFLOW-1:0][SEQ_W-1:0] rel;
    } seq_st_t;

    seq_st_t seq_q, seq_d;

    always_comb begin
        seq_d = seq_q;
        if (asg_en) begin
            seq_d.asg[asg_flow] = seq_q.asg[asg_flow] + SEQ_W'(1);
        end
        if (rel_en) begin
            seq_d.rel[rel_flow] = seq_q.rel[rel_flow] + SEQ_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign asg_seq  = seq_q.asg[asg_flow];
    assign head_seq = seq_q.rel;

    // R8: outstanding packets of a flow never exceed the context count,
    // so stamps never alias within one flow
    for (genvar f = 0; f < NFLOW; f++) begin : g_bound
        p_outstanding_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
            int'(SEQ_W'(seq_q.asg[f] - seq_q.rel[f])) <= NT);
    end

endmodule

// File: rtl/pkt_thread_dispatch.sv
// Packet-to-thread dispatcher: NUM_ENG engines x 4 contexts, flow-ordered release.
// NUM_ENG must be a power of two, at least 2; SEQ_W must exceed log2 of the context count.
module pkt_thread_dispatch
    import pd_pkg::*;
#(
    parameter int NUM_ENG = 2,
    parameter int FLOW_W  = 2,
    parameter int DATA_W  = 16,
    parameter int LAT_W   = 6,
    parameter int SEQ_W   = 4,
    localparam int ENG_W  = $clog2(NUM_ENG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [FLOW_W-1:0] in_flow,
    input  logic [DATA_W-1:0] in_data,
    input  logic [LAT_W-1:0]  in_lat,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [FLOW_W-1:0] out_flow,
    output logic [SEQ_W-1:0]  out_seq,
    output logic [DATA_W-1:0] out_data,
    output logic [ENG_W-1:0]  out_eng,
    output logic [1:0]        out_ctx
);

    localparam int CTX_PER_ENG = 4;
    localparam int NT          = NUM_ENG * CTX_PER_ENG;
    localparam int SLOT_W      = $clog2(NT);
    localparam int NFLOW       = 1 << FLOW_W;

    typedef struct packed {
        thr_state_e        st;
        logic [FLOW_W-1:0] flow;
        logic [SEQ_W-1:0]  seq;
        logic [DATA_W-1:0] data;
        logic [LAT_W-1:0]  cnt;
    } thr_t;

    typedef struct packed {
        thr_t [NT-1:0]     thr;
        logic [SLOT_W-1:0] rr;
        logic              hold;
        logic [SLOT_W-1:0] hold_slot;
    } disp_st_t;

    disp_st_t q, d;

    logic [NT-1:0]               free_vec;
    logic [NT-1:0]               done_vec;
    logic [NT-1:0][FLOW_W-1:0]   flow_vec;
    logic [NT-1:0][SEQ_W-1:0]    seq_vec;
    logic [NFLOW-1:0][SEQ_W-1:0] head_seq;
    logic                        alloc_found;
    logic [SLOT_W-1:0]           alloc_slot;
    logic                        pick_found;
    logic [SLOT_W-1:0]           pick_slot;
    logic [SLOT_W-1:0]           rel_slot;
    logic [SEQ_W-1:0]            asg_seq;
    logic                        acc;
    logic                        rel_fire;

    always_comb begin
        for (int i = 0; i < NT; i++) begin
            free_vec[i] = (q.thr[i].st == TS_FREE);
            done_vec[i] = (q.thr[i].st == TS_DONE);
            flow_vec[i] = q.thr[i].flow;
            seq_vec[i]  = q.thr[i].seq;
        end
    end

    pd_slot_alloc #(.NT(NT)) u_alloc (
        .free_vec (free_vec),
        .start    (q.rr),
        .found    (alloc_found),
        .slot     (alloc_slot)
    );

    pd_rel_pick #(.NT(NT), .FLOW_W(FLOW_W), .SEQ_W(SEQ_W)) u_pick (
        .done_vec (done_vec),
        .flow_vec (flow_vec),
        .seq_vec  (seq_vec),
        .head_seq (head_seq),
        .found    (pick_found),
        .slot     (pick_slot)
    );

    pd_flow_seq #(.FLOW_W(FLOW_W), .SEQ_W(SEQ_W), .NT(NT)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .asg_en   (acc),
        .asg_flow (in_flow),
        .asg_seq  (asg_seq),
        .rel_en   (rel_fire),
        .rel_flow (out_flow),
        .head_seq (head_seq)
    );

    // Handshakes; an offer that was not taken stays locked to its slot
    assign in_ready  = alloc_found;
    assign acc       = in_valid && alloc_found;
    assign rel_slot  = q.hold ? q.hold_slot : pick_slot;
    assign out_valid = q.hold || pick_found;
    assign rel_fire  = out_valid && out_ready;

    assign out_flow  = q.thr[rel_slot].flow;
    assign out_seq   = q.thr[rel_slot].seq;
    assign out_data  = q.thr[rel_slot].data;
    assign out_eng   = rel_slot[ENG_W-1:0];
    assign out_ctx   = rel_slot[SLOT_W-1:ENG_W];

    always_comb begin
        d = q;
        for (int i = 0; i < NT; i++) begin
            if (q.thr[i].st == TS_BUSY) begin
                if (q.thr[i].cnt == '0) begin
                    d.thr[i].st = TS_DONE;
                end else begin
                    d.thr[i].cnt = q.thr[i].cnt - LAT_W'(1);
                end
            end
        end
        if (rel_fire) begin
            d.thr[rel_slot].st = TS_FREE;
        end
        if (acc) begin
            d.thr[alloc_slot].st   = TS_BUSY;
            d.thr[alloc_slot].flow = in_flow;
            d.thr[alloc_slot].seq  = asg_seq;
            d.thr[alloc_slot].data = in_data;
            d.thr[alloc_slot].cnt  = in_lat;
            d.rr                   = alloc_slot + SLOT_W'(1);
        end
        d.hold      = out_valid && !out_ready;
        d.hold_slot = rel_slot;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    // R2: with every context occupied, input is refused
    p_full_blocks_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(free_vec) == 0) |-> !in_ready);

    // R6: the offered packet is always the head of its flow
    p_release_in_order_r6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_seq == head_seq[out_flow]));

    // R9: an offer that is not taken stays unchanged
    p_offer_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)
                                       && $stable(out_flow) && $stable(out_seq)));

    // R9: the released context is free in the next cycle
    p_slot_freed_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rel_fire |=> free_vec[$past(rel_slot)]);

    for (genvar g = 0; g < NT; g++) begin : g_ctx_chk
        // R4: countdown at zero finishes on the next edge
        p_finish_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (q.thr[g].st == TS_BUSY && q.thr[g].cnt == '0) |=> (q.thr[g].st == TS_DONE));
        // R5: a running context keeps running regardless of others
        p_independent_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (q.thr[g].st == TS_BUSY && q.thr[g].cnt != '0) |=> (q.thr[g].st == TS_BUSY));
        // R7: a parked context is never handed out again
        p_parked_kept_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (q.thr[g].st == TS_DONE && !(rel_fire && rel_slot == SLOT_W'(g)))
            |=> (q.thr[g].st == TS_DONE));
    end

endmodule

// File: tb/sim_pkt_thread_dispatch.sv
module sim_pkt_thread_dispatch;

    localparam int NE = 2;
    localparam int FW = 2;
    localparam int DW = 16;
    localparam int LW = 6;
    localparam int SW = 4;

    // Vector fields: flow [23:22], latency [21:16], payload [15:0]
    localparam logic [23:0] VEC [12] = '{
        {2'd0, 6'd30, 16'h1000}, {2'd1, 6'd5,  16'h2000}, {2'd0, 6'd3,  16'h1001},
        {2'd2, 6'd12, 16'h3000}, {2'd1, 6'd1,  16'h2001}, {2'd0, 6'd0,  16'h1002},
        {2'd3, 6'd8,  16'h4000}, {2'd2, 6'd0,  16'h3001}, {2'd3, 6'd2,  16'h4001},
        {2'd1, 6'd9,  16'h2002}, {2'd0, 6'd6,  16'h1003}, {2'd2, 6'd1,  16'h3002}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [FW-1:0] in_flow = '0;
    logic [DW-1:0] in_data = '0;
    logic [LW-1:0] in_lat = '0;
    logic          out_valid;
    logic          out_ready = 1'b0;
    logic [FW-1:0] out_flow;
    logic [SW-1:0] out_seq;
    logic [DW-1:0] out_data;
    logic [0:0]    out_eng;
    logic [1:0]    out_ctx;

    pkt_thread_dispatch #(.NUM_ENG(NE), .FLOW_W(FW), .DATA_W(DW), .LAT_W(LW), .SEQ_W(SW)) u0 (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_flow(in_flow),
        .in_data(in_data), .in_lat(in_lat),
        .out_valid(out_valid), .out_ready(out_ready), .out_flow(out_flow),
        .out_seq(out_seq), .out_data(out_data), .out_eng(out_eng), .out_ctx(out_ctx)
    );

    int total = 0;
    int bad = 0;
    int sent = 0;
    int got = 0;
    int cf;
    logic [DW-1:0] expq [4][64];
    int wr_i [4];
    int rd_i [4];
    logic [DW-1:0] log_data [256];
    int log_eng [256];
    int log_ctx [256];

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) begin
            @(posedge clk);
            #1;
        end
    endtask

    // Reference: per-flow queues of payloads in acceptance order
    always @(negedge clk) begin
        if (!rst_n) begin
            for (int f = 0; f < 4; f++) rd_i[f] = 0;
        end else if (out_valid && out_ready) begin
            cf = int'(out_flow);
            chk(rd_i[cf] < wr_i[cf], "R2", "release with nothing pending", rd_i[cf], wr_i[cf]);
            chk(out_data == expq[cf][rd_i[cf] % 64], "R6", "flow order payload",
                int'(out_data), int'(expq[cf][rd_i[cf] % 64]));
            chk(out_seq == SW'(rd_i[cf]), "R8", "sequence stamp",
                int'(out_seq), rd_i[cf] % 16);
            log_data[got % 256] = out_data;
            log_eng[got % 256]  = int'(out_eng);
            log_ctx[got % 256]  = int'(out_ctx);
            rd_i[cf]++;
            got++;
        end
    end

    task automatic do_reset();
        in_valid  = 1'b0;
        out_ready = 1'b0;
        rst_n     = 1'b0;
        for (int f = 0; f < 4; f++) wr_i[f] = 0;
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
    endtask

    task automatic send(input int fl, input logic [DW-1:0] dat, input int lat);
        bit fire;
        fire     = 1'b0;
        in_valid = 1'b1;
        in_flow  = FW'(fl);
        in_data  = dat;
        in_lat   = LW'(lat);
        while (!fire) begin
            @(negedge clk);
            fire = in_ready;
            @(posedge clk);
            #1;
        end
        in_valid = 1'b0;
        expq[fl][wr_i[fl] % 64] = dat;
        wr_i[fl]++;
        sent++;
    endtask

    task automatic drain();
        int n;
        n = 0;
        out_ready = 1'b1;
        while (got != sent && n < 3000) begin
            tick(1);
            n++;
        end
        tick(2);
        chk(got == sent, "R2", "every accepted packet released", got, sent);
    endtask

    initial begin
        int base;
        int n;

        // R1: reset state
        do_reset();
        @(negedge clk);
        chk(in_ready == 1'b1, "R1", "in_ready after reset", int'(in_ready), 1);
        chk(out_valid == 1'b0, "R1", "out_valid after reset", int'(out_valid), 0);
        tick(1);

        // R4: single packet latency, R3 first grant
        do_reset();
        send(1, 16'hA001, 5);
        tick(5);
        @(negedge clk);
        chk(out_valid == 1'b0, "R4", "not finished at edge k+L", int'(out_valid), 0);
        tick(1);
        @(negedge clk);
        chk(out_valid == 1'b1, "R4", "finished after edge k+L+1", int'(out_valid), 1);
        chk(out_eng == 1'b0 && out_ctx == 2'd0, "R3", "first grant eng0 ctx0",
            int'(out_eng) * 4 + int'(out_ctx), 0);
        drain();

        // R3 grant rotation and R10 lowest-slot release
        do_reset();
        base = got;
        send(0, 16'hB000, 0);
        send(1, 16'hB001, 0);
        send(2, 16'hB002, 0);
        tick(3);
        drain();
        chk(log_eng[base % 256] == 0 && log_ctx[base % 256] == 0, "R3", "grant 0 eng*4+ctx",
            log_eng[base % 256] * 4 + log_ctx[base % 256], 0);
        chk(log_eng[(base + 1) % 256] == 1 && log_ctx[(base + 1) % 256] == 0, "R3",
            "grant 1 eng*4+ctx", log_eng[(base + 1) % 256] * 4 + log_ctx[(base + 1) % 256], 4);
        chk(log_eng[(base + 2) % 256] == 0 && log_ctx[(base + 2) % 256] == 1, "R3",
            "grant 2 eng*4+ctx", log_eng[(base + 2) % 256] * 4 + log_ctx[(base + 2) % 256], 1);
        chk(log_data[(base + 1) % 256] == 16'hB001, "R10", "second release payload",
            int'(log_data[(base + 1) % 256]), 'hB001);

        // R7 parked contexts stay busy, R6 hold-back, R9 free after acceptance
        do_reset();
        send(0, 16'hA0A0, 40);
        for (int i = 1; i < 8; i++) send(0, DW'(16'hC000 + i), 0);
        tick(3);
        @(negedge clk);
        chk(in_ready == 1'b0, "R7", "all contexts held, in_ready", int'(in_ready), 0);
        chk(out_valid == 1'b0, "R6", "finished successors held back", int'(out_valid), 0);
        n = 0;
        while (!out_valid && n < 100) begin
            @(negedge clk);
            n++;
        end
        chk(out_data == 16'hA0A0, "R6", "oldest of flow offered first", int'(out_data), 'hA0A0);
        @(posedge clk);
        #1;
        out_ready = 1'b1;
        tick(1);
        out_ready = 1'b0;
        @(negedge clk);
        chk(in_ready == 1'b1, "R9", "context free after acceptance", int'(in_ready), 1);
        @(posedge clk);
        #1;
        send(2, 16'hD000, 0);
        drain();

        // R5: another flow is not delayed by a long packet
        do_reset();
        out_ready = 1'b1;
        base = got;
        send(0, 16'hE000, 50);
        send(1, 16'hF000, 2);
        n = 0;
        while (got == base && n < 200) begin
            tick(1);
            n++;
        end
        chk(log_data[base % 256] == 16'hF000, "R5", "short other-flow packet first",
            int'(log_data[base % 256]), 'hF000);
        drain();

        // Table walk with varying back-pressure (R6, R8, R9)
        do_reset();
        for (int i = 0; i < 12; i++) begin
            out_ready = (i % 3 != 0);
            send(int'(VEC[i][23:22]), VEC[i][15:0], int'(VEC[i][21:16]));
        end
        drain();

        // R8: stamp wraps past 2^SW within one flow
        do_reset();
        out_ready = 1'b1;
        for (int i = 0; i < 18; i++) send(3, DW'(16'h3000 + i), (i * 7) % 5);
        drain();

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(4 * 150000);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule